// File: doc/BRIEF.md
# Interrupt Aggregator with Normal and Fast Outputs

This block gathers a set of level-sensitive interrupt lines and presents them to a processor as two request wires: a normal interrupt and a fast interrupt. Software drives it over a small 32-bit register bus.

Software turns lines on through a write-one-to-set register and off through a separate write-one-to-clear register. It reads which enabled lines are pending. It steers each line to either output. It can invert the sense of a small, fixed subset of lines so that they are active-low. For test, software can select a software-written source vector in place of the real input pins.

The request outputs are combinational from the inputs and the register state. No line is latched: a line is pending exactly while its input is active. The path from an input to a request runs in this order:

1. Source select picks either the pins or the test vector.
2. The polarity register inverts the lines it covers.
3. The enable vector masks the result.
4. The routing register splits the masked lines between the normal and fast outputs.

Top module: `intc_core`

## Requirements
- R1: After reset, every enable, routing, polarity, source-select and test-source bit is 0. Both outputs are low, and every register reads 0.
- R2: A write to the set register (word address 1) sets each enable bit whose data bit is 1. Bits written 0 keep their value. Reading address 1 returns the enable vector.
- R3: A write to the clear register (word address 2) clears each enable bit whose data bit is 1. Bits written 0 keep their value. Reading address 2 returns the enable vector.
- R4: The status register (word address 0, read-only) reads as the active lines ANDed with the enable vector.
- R5: The routing register (word address 3) sends a line to `irq_o` when its bit is 0 and to `fiq_o` when its bit is 1. `irq_o` is the OR of the pending lines routed to it, and `fiq_o` is the OR of the pending lines routed to it.
- R6: The polarity register (word address 4) makes a line active-low when its bit is 1. Only the lines set in parameter `LOWCAP` accept the bit; by default these are lines 4 and 6 (value 0x050). All other polarity bits stay 0, read 0 and have no effect.
- R7: When bit 0 of the source-select register (word address 5) is 1, the test-source register (word address 6) replaces `irq_in`. Polarity is applied after this selection.
- R8: Lines are level-sensitive. A pending line and its output drop as soon as its input goes inactive, with no clearing write.
- R9: Read data appears on `bus_rdata` in the cycle after the read strobe is sampled and holds until the next read. Word addresses 7 to 15 and bit positions at or above `N` read 0. A write takes effect at the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N | Interrupt input lines |
| bus_addr | input | 4 | Word address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach is the interaction of polarity and routing on an active-low line. With its input low and its polarity bit set, that line must assert exactly one output, chosen by its route bit. Lines without active-low support must ignore the same polarity write. To reach every such case, the stimulus sweeps all 1024 input patterns under several enable, route and polarity configurations, then repeats the sweep through the test source. After each pattern it compares both outputs and the status read against values the bench computes for that pattern.

// File: rtl/intc_core.sv
module intc_core #(
  parameter int N = 10,
  parameter logic [N-1:0] LOWCAP = 10'h050
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [3:0]   bus_addr,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  output logic         irq_o,
  output logic         fiq_o
);
  localparam logic [3:0] A_STAT = 4'd0, A_ENSET = 4'd1, A_ENCLR = 4'd2, A_ROUTE = 4'd3,
                         A_POL = 4'd4, A_TSEL = 4'd5, A_TSRC = 4'd6;
  localparam int PADW = 32 - N;

  logic [N-1:0] en_q, route_q, pol_q, tsrc_q;
  logic         tsel_q;
  logic [N-1:0] wd, active, pend;
  logic [N-1:0] rd_mux;
  logic         unused_wd;

  assign wd = bus_wdata[N-1:0];
  assign unused_wd = &{1'b0, bus_wdata[31:N]};

  assign active = (tsel_q ? tsrc_q : irq_in) ^ pol_q;
  assign pend   = active & en_q;
  assign irq_o  = |(pend & ~route_q);
  assign fiq_o  = |(pend & route_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
      pol_q   <= '0;
      tsel_q  <= 1'b0;
      tsrc_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_ENSET: en_q    <= en_q | wd;
        A_ENCLR: en_q    <= en_q & ~wd;
        A_ROUTE: route_q <= wd;
        A_POL:   pol_q   <= wd & LOWCAP;
        A_TSEL:  tsel_q  <= wd[0];
        A_TSRC:  tsrc_q  <= wd;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_STAT:           rd_mux = pend;
      A_ENSET, A_ENCLR: rd_mux = en_q;
      A_ROUTE:          rd_mux = route_q;
      A_POL:            rd_mux = pol_q;
      A_TSEL:           rd_mux = {{(N-1){1'b0}}, tsel_q};
      A_TSRC:           rd_mux = tsrc_q;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= {{PADW{1'b0}}, rd_mux};
  end
endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk #(
  parameter int N = 10,
  parameter logic [N-1:0] LOWCAP = 10'h050
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   bus_addr,
  input logic         bus_wr,
  input logic         bus_rd,
  input logic [31:0]  bus_wdata,
  input logic [31:0]  bus_rdata,
  input logic         irq_o,
  input logic         fiq_o,
  input logic [N-1:0] en_q,
  input logic [N-1:0] pol_q
);
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd1) |=> ((en_q & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])
                                      && ((en_q ^ $past(en_q)) & ~$past(bus_wdata[N-1:0])) == '0));

  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd2) |=> ((en_q & $past(bus_wdata[N-1:0])) == '0
                                      && ((en_q ^ $past(en_q)) & ~$past(bus_wdata[N-1:0])) == '0));

  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (!irq_o && !fiq_o));

  p_polcap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_q & ~LOWCAP) == '0);

  p_rdhold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && rst_n) |=> $stable(bus_rdata));

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:N] == '0);
endmodule

bind intc_core intc_core_chk #(.N(N), .LOWCAP(LOWCAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o),
  .en_q(en_q), .pol_q(pol_q)
);

// File: tb/intc_core_test.sv
module intc_core_test;
  localparam int N = 10;
  localparam logic [N-1:0] LOWCAP = 10'h050;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_in = '0;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_o, fiq_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [N-1:0] m_en = '0, m_route = '0, m_pol = '0, m_tsrc = '0;
  logic m_tsel = 0;

  intc_core #(.N(N), .LOWCAP(LOWCAP)) uut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual %0d expected <150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
    case (a)
      4'd1: m_en = m_en | d[N-1:0];
      4'd2: m_en = m_en & ~d[N-1:0];
      4'd3: m_route = d[N-1:0];
      4'd4: m_pol = d[N-1:0] & LOWCAP;
      4'd5: m_tsel = d[0];
      4'd6: m_tsrc = d[N-1:0];
      default: ;
    endcase
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  function automatic logic [N-1:0] pend_of(logic [N-1:0] pins);
    return ((m_tsel ? m_tsrc : pins) ^ m_pol) & m_en;
  endfunction

  task automatic sweep_point(string req, logic [N-1:0] v);
    logic [31:0] d;
    logic [N-1:0] p;
    @(negedge clk);
    irq_in = v;
    #2;
    p = pend_of(v);
    check({req, " irq_o"}, {31'b0, irq_o}, {31'b0, |(p & ~m_route)});
    check({req, " fiq_o"}, {31'b0, fiq_o}, {31'b0, |(p & m_route)});
    rd(4'd0, d);
    check({req, " status R4"}, d, {22'b0, p});
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    check("R1 irq_o", {31'b0, irq_o}, 0);
    check("R1 fiq_o", {31'b0, fiq_o}, 0);
    for (int a = 0; a < 16; a++) begin
      rd(a[3:0], d);
      check(a < 7 ? "R1 reset read" : "R9 unmapped read", d, 0);
    end

    wr(4'd1, 32'h005); wr(4'd1, 32'h300);
    rd(4'd1, d); check("R2 set keeps zeros", d, 32'h305);
    wr(4'd2, 32'h0F0); rd(4'd2, d); check("R3 clr no effect on clear bits", d, 32'h305);
    wr(4'd2, 32'h104); rd(4'd1, d); check("R3 clear", d, 32'h201);
    wr(4'd1, 32'hFFFF_FFFF); rd(4'd2, d); check("R9 upper bits zero", d, 32'h3FF);
    wr(4'd4, 32'hFFFF_FFFF); rd(4'd4, d); check("R6 only capable bits", d, {22'b0, LOWCAP});
    wr(4'd4, 0);

    begin
      logic [N-1:0] cen[4] = '{10'h3FF, 10'h3FF, 10'h155, 10'h0F0};
      logic [N-1:0] crt[4] = '{10'h000, 10'h2A5, 10'h3FF, 10'h050};
      logic [N-1:0] cpl[4] = '{10'h000, 10'h050, 10'h3FF, 10'h010};
      for (int c = 0; c < 4; c++) begin
        wr(4'd2, 32'h3FF); wr(4'd1, {22'b0, cen[c]});
        wr(4'd3, {22'b0, crt[c]}); wr(4'd4, {22'b0, cpl[c]});
        for (int v = 0; v < 1024; v++) sweep_point("R5 R6 sweep", v[N-1:0]);
      end
    end

    wr(4'd1, 32'h3FF); wr(4'd3, 32'h00F); wr(4'd4, 32'h040);
    wr(4'd5, 1);
    for (int v = 0; v < 1024; v++) begin
      if (v[0]) wr(4'd6, v);
      else begin @(negedge clk); m_tsrc = m_tsrc; end
      sweep_point("R7 test source", ~v[N-1:0]);
    end
    wr(4'd5, 0); wr(4'd4, 0); wr(4'd3, 0);

    wr(4'd2, 32'h3FF); wr(4'd1, 32'h008);
    @(negedge clk); irq_in = 10'h008; #2;
    check("R8 asserted", {31'b0, irq_o}, 1);
    @(negedge clk); irq_in = 10'h000; #2;
    check("R8 drop without clear", {31'b0, irq_o}, 0);
    rd(4'd0, d); check("R8 status cleared", d, 0);

    @(negedge clk); bus_addr = 4'd1; bus_rd = 1;
    @(negedge clk); bus_rd = 0; bus_addr = 4'd9;
    repeat (2) @(negedge clk);
    check("R9 read data holds", bus_rdata, 32'h008);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule